// File: doc/BRIEF.md
# SHA-512 paired half-round hash update unit

This unit carries out one hash-state update step of SHA-512 on 128-bit vector operands. Each operand holds two 64-bit words: lane 0 in bits 63:0 and lane 1 in bits 127:64. The accumulator operand D is updated using two source operands, N and M. One select bit picks which update is applied:

- **First-half update (select 0):** uses the choose function and the big Sigma1 rotation mix.
- **Second-half update (select 1):** uses the majority function and the big Sigma0 rotation mix.

In both updates, lane 1 of the result is computed first. That new lane 1 value then feeds the lane 0 computation, so one operation performs two dependent half-rounds.

The arithmetic is combinational. A single output register captures the result when an input strobe is seen, and raises a one-cycle valid pulse alongside it. The surrounding pipeline is responsible for:

- reading the operands from its register file,
- the message schedule,
- adding round constants into the operands.

Top module: `hash_round_pair`

## Requirements
- R1: After reset is released, and before any input strobe, `out_valid_o` is 0 and `res_o` is all zeros.
- R2: Each cycle with `in_valid_i` high produces a result on `res_o`, and `out_valid_o` is high exactly in the following cycle. A cycle without the strobe gives `out_valid_o` low in the following cycle.
- R3: With `op_sel_i`=0, `res_o[127:64]` = D1 + S1(M1) + Ch(M1,N0,N1).
  - Ch(x,y,z) selects y where x is 1 and z where x is 0.
  - S1(x) = rotr14(x) ^ rotr18(x) ^ rotr41(x).
  - D0, D1, N0, N1, M0, M1 denote bits 63:0 and 127:64 of `d_i`, `n_i`, `m_i`.
- R4: With `op_sel_i`=0, `res_o[63:0]` = D0 + S1(T) + Ch(T,M1,N0), where T is the new lane 1 value plus M0.
- R5: With `op_sel_i`=1, `res_o[127:64]` = D1 + S0(M0) + Maj(N0,M1,M0).
  - Maj is the bitwise majority of its three inputs.
  - S0(x) = rotr28(x) ^ rotr34(x) ^ rotr39(x).
- R6: With `op_sel_i`=1, `res_o[63:0]` = D0 + S0(E) + Maj(E,M0,M1), where E is the new lane 1 value.
- R7: Every sum wraps modulo 2^64, and no carry passes from lane 0 into lane 1.
- R8: While `in_valid_i` is low, changes on `d_i`, `n_i`, `m_i` and `op_sel_i` leave `res_o` unchanged.
- R9: Strobes on consecutive cycles give results on consecutive cycles, each result belonging to its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand strobe |
| op_sel_i | input | 1 | 0: choose/Sigma1 update, 1: majority/Sigma0 update |
| d_i | input | 128 | Accumulator operand D |
| n_i | input | 128 | Source operand N |
| m_i | input | 128 | Source operand M |
| res_o | output | 128 | Updated D |
| out_valid_o | output | 1 | Result valid pulse |

## Verification
The bench builds the unit with its fixed 64-bit lane width, so the configuration never changes. The sweep therefore runs along the operand bits instead:

- a single bit is walked through every position of D, N and M under both select values, against a fixed random background;
- each rotation tap and each lane-crossing term is then exercised individually;
- all-ones operands drive every lane sum into wrap-around;
- a long pseudo-random run and consecutive strobes complete the coverage.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  localparam int LANE_W = 64;
  localparam int VEC_W  = 2 * LANE_W;
  localparam int NLANE  = VEC_W / LANE_W;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [VEC_W-1:0]  vec_t;

  function automatic lane_t rotr(lane_t x, int k);
    return (x >> k) | (x << (LANE_W - k));
  endfunction

  function automatic lane_t f_ch(lane_t x, lane_t y, lane_t z);
    return (x & (y ^ z)) ^ z;
  endfunction

  function automatic lane_t f_maj(lane_t x, lane_t y, lane_t z);
    return (x & y) | ((x | y) & z);
  endfunction

  function automatic lane_t big_sig0(lane_t x);
    return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
  endfunction

  function automatic lane_t big_sig1(lane_t x);
    return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
  endfunction
endpackage

// File: rtl/hrp_lane1.sv
module hrp_lane1
  import hrp_pkg::*;
(
  input  logic  op_sel_i,
  input  lane_t d1_i,
  input  lane_t n0_i,
  input  lane_t n1_i,
  input  lane_t m0_i,
  input  lane_t m1_i,
  output lane_t d1_o
);
  lane_t mix, logic_term;

  always_comb begin
    if (!op_sel_i) begin
      mix        = big_sig1(m1_i);
      logic_term = f_ch(m1_i, n0_i, n1_i);
    end else begin
      mix        = big_sig0(m0_i);
      logic_term = f_maj(n0_i, m1_i, m0_i);
    end
  end

  assign d1_o = d1_i + mix + logic_term;
endmodule

// File: rtl/hrp_lane0.sv
module hrp_lane0
  import hrp_pkg::*;
(
  input  logic  op_sel_i,
  input  lane_t d0_i,
  input  lane_t d1_new_i,
  input  lane_t n0_i,
  input  lane_t m0_i,
  input  lane_t m1_i,
  output lane_t d0_o
);
  lane_t t, mix, logic_term;

  always_comb begin
    t = d1_new_i + m0_i;
    if (!op_sel_i) begin
      mix        = big_sig1(t);
      logic_term = f_ch(t, m1_i, n0_i);
    end else begin
      mix        = big_sig0(d1_new_i);
      logic_term = f_maj(d1_new_i, m0_i, m1_i);
    end
  end

  assign d0_o = d0_i + mix + logic_term;
endmodule

// File: rtl/hrp_out_reg.sv
module hrp_out_reg #(
  parameter int W = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= en_i;
      if (en_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/hash_round_pair.sv
module hash_round_pair
  import hrp_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic         op_sel_i,
  input  logic [127:0] d_i,
  input  logic [127:0] n_i,
  input  logic [127:0] m_i,
  output logic [127:0] res_o,
  output logic         out_valid_o
);
  lane_t d_l [NLANE];
  lane_t n_l [NLANE];
  lane_t m_l [NLANE];
  lane_t d1_new, d0_new;

  for (genvar g = 0; g < NLANE; g++) begin : g_split
    assign d_l[g] = d_i[g*LANE_W +: LANE_W];
    assign n_l[g] = n_i[g*LANE_W +: LANE_W];
    assign m_l[g] = m_i[g*LANE_W +: LANE_W];
  end

  hrp_lane1 u_lane1 (
    .op_sel_i (op_sel_i),
    .d1_i     (d_l[1]),
    .n0_i     (n_l[0]),
    .n1_i     (n_l[1]),
    .m0_i     (m_l[0]),
    .m1_i     (m_l[1]),
    .d1_o     (d1_new)
  );

  // lane 0 consumes the fresh lane 1 result
  hrp_lane0 u_lane0 (
    .op_sel_i (op_sel_i),
    .d0_i     (d_l[0]),
    .d1_new_i (d1_new),
    .n0_i     (n_l[0]),
    .m0_i     (m_l[0]),
    .m1_i     (m_l[1]),
    .d0_o     (d0_new)
  );

  hrp_out_reg #(.W(VEC_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (in_valid_i),
    .d_i    ({d1_new, d0_new}),
    .q_o    (res_o),
    .vld_o  (out_valid_o)
  );

  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(res_o));
  assert_first_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !op_sel_i) |=> res_o[127:64] == lane_t'($past(d_l[1])
      + big_sig1($past(m_l[1])) + f_ch($past(m_l[1]), $past(n_l[0]), $past(n_l[1]))));
  assert_first_link_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !op_sel_i) |=> res_o[63:0] == lane_t'($past(d_l[0])
      + big_sig1(lane_t'(res_o[127:64] + $past(m_l[0])))
      + f_ch(lane_t'(res_o[127:64] + $past(m_l[0])), $past(m_l[1]), $past(n_l[0]))));
  assert_second_link_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_sel_i) |=> res_o[63:0] == lane_t'($past(d_l[0])
      + big_sig0(res_o[127:64]) + f_maj(res_o[127:64], $past(m_l[0]), $past(m_l[1]))));
endmodule

// File: tb/hash_round_pair_tb.sv
module hash_round_pair_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic         op_sel_i = 1'b0;
  logic [127:0] d_i = '0, n_i = '0, m_i = '0;
  logic [127:0] res_o;
  logic         out_valid_o;

  int checks = 0;
  int failures = 0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #2 clk_i = ~clk_i;

  hash_round_pair u_dut (.*);

  function automatic logic [63:0] rr(logic [63:0] x, int k);
    logic [127:0] w;
    w = {x, x} >> k;
    return w[63:0];
  endfunction
  function automatic logic [63:0] chr(logic [63:0] x, y, z);
    return (x & y) | (~x & z);
  endfunction
  function automatic logic [63:0] mjr(logic [63:0] x, y, z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction
  function automatic logic [63:0] s0r(logic [63:0] x);
    return rr(x, 39) ^ rr(x, 28) ^ rr(x, 34);
  endfunction
  function automatic logic [63:0] s1r(logic [63:0] x);
    return rr(x, 41) ^ rr(x, 14) ^ rr(x, 18);
  endfunction

  function automatic logic [127:0] model(logic op, logic [127:0] d, n, m);
    logic [63:0] hi, lo, t;
    if (!op) begin
      hi = d[127:64] + s1r(m[127:64]) + chr(m[127:64], n[63:0], n[127:64]);
      t  = hi + m[63:0];
      lo = d[63:0] + s1r(t) + chr(t, m[127:64], n[63:0]);
    end else begin
      hi = d[127:64] + s0r(m[63:0]) + mjr(n[63:0], m[127:64], m[63:0]);
      lo = d[63:0] + s0r(hi) + mjr(hi, m[63:0], m[127:64]);
    end
    return {hi, lo};
  endfunction

  function automatic logic [63:0] step(logic [63:0] s);
    return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_one(string req, logic op, logic [127:0] d, n, m);
    @(negedge clk_i);
    in_valid_i = 1'b1; op_sel_i = op; d_i = d; n_i = n; m_i = m;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk("R2", {127'd0, out_valid_o}, 128'd1);
    chk(req, res_o, model(op, d, n, m));
  endtask

  function automatic logic [127:0] rnd128();
    logic [127:0] v;
    lfsr = step(lfsr); v[127:64] = lfsr;
    lfsr = step(lfsr); v[63:0] = lfsr;
    return v;
  endfunction

  initial begin
    logic [127:0] bd, bn, bm, keep, a0, a1;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", {127'd0, out_valid_o}, 128'd0);
    chk("R1", res_o, 128'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", {127'd0, out_valid_o}, 128'd0);
    chk("R1", res_o, 128'd0);

    // R7: all-ones wrap, constant hi lane = 3 * (2^64-1) mod 2^64
    run_one("R7", 1'b0, '1, '1, '1);
    chk("R7", {64'd0, res_o[127:64]}, {64'd0, 64'hFFFF_FFFF_FFFF_FFFD});
    run_one("R7", 1'b1, '1, '1, '1);
    run_one("R3", 1'b0, '0, '0, '0);
    chk("R3", res_o, 128'd0);

    bd = rnd128(); bn = rnd128(); bm = rnd128();
    for (int op = 0; op < 2; op++) begin
      for (int b = 0; b < 128; b++) begin
        run_one(op ? "R5" : "R3", op[0], bd ^ (128'd1 << b), bn, bm);
        run_one(op ? "R6" : "R4", op[0], bd, bn ^ (128'd1 << b), bm);
        run_one(op ? "R6" : "R4", op[0], bd, bn, bm ^ (128'd1 << b));
        run_one("R7", op[0], 128'd1 << b, 128'd1 << b, 128'd1 << b);
      end
    end
    for (int i = 0; i < 300; i++)
      run_one(i[0] ? "R6" : "R4", i[0], rnd128(), rnd128(), rnd128());

    // R8: inputs ignored without strobe
    run_one("R8", 1'b1, bd, bn, bm);
    keep = res_o;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      op_sel_i = ~op_sel_i; d_i = rnd128(); n_i = rnd128(); m_i = rnd128();
      @(negedge clk_i);
      chk("R8", res_o, keep);
      chk("R8", {127'd0, out_valid_o}, 128'd0);
    end

    // R9: back-to-back strobes
    a0 = rnd128(); a1 = rnd128();
    @(negedge clk_i);
    in_valid_i = 1'b1; op_sel_i = 1'b0; d_i = a0; n_i = a1; m_i = bm;
    @(negedge clk_i);
    chk("R9", res_o, model(1'b0, a0, a1, bm));
    op_sel_i = 1'b1; d_i = a1; n_i = bn; m_i = a0;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk("R9", res_o, model(1'b1, a1, bn, a0));
    chk("R9", {127'd0, out_valid_o}, 128'd1);
    @(negedge clk_i);
    chk("R2", {127'd0, out_valid_o}, 128'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule